// File: doc/BRIEF.md
# Time-Slotted Overrange Flag Serializer

This block turns the two per-channel overrange pulses of a stereo conversion path into one active-low overflow line that a host can read alongside the serial audio stream. Each channel keeps a sticky flag that drops the line's status low the moment an overrange arrives. One timer is shared by both channels, and any overrange on either side restarts it. When a fixed number of frames has passed with no new overrange, both flags release together.

The line carries the left and right status in turn. Each half of the frame gets one slot, and the slot changes a short, format-dependent number of serial-clock periods after each frame-clock transition. The host can therefore latch each channel's status on a frame-clock edge. The serial clock and the frame clock are sampled by the block's system clock, and the output is a push-pull stand-in for an open-drain pin.

Top module: `ovr_slot_mux`

## Requirements
- R1: While `rst_n` is low and after it is released, `ovfl_n_o` is 1, both channel flags are clear and the hold timer is zero.
- R2: A one-cycle high on `ovr_l_i` (or `ovr_r_i`) sets that channel's flag in the next cycle. The line then shows 0 at that channel's next slot update.
- R3: A set flag stays set until the 2^HOLD_LOG2-th frame-clock rising edge counted after the most recent overrange. At that edge both flags clear, and later slot updates show 1.
- R4: An overrange on either channel restarts the shared hold count, so a flag set earlier on the other channel also stays set for the full new window.
- R5: With `fmt_i2s_i` = 0 (left-justified), the line updates on the first serial-clock falling edge after a frame-clock transition. A falling edge that coincides with the transition does not count.
- R6: With `fmt_i2s_i` = 1 (I2S), the line updates on the second serial-clock falling edge after a frame-clock transition.
- R7: With `fmt_i2s_i` = 0, the half in which the frame clock is low carries the right status and the high half carries the left status. With `fmt_i2s_i` = 1, the low half carries the left status and the high half carries the right status.
- R8: `ovfl_n_o` changes only at a slot update, so it holds its value for the rest of each half-frame.
- R9: An overrange in the same cycle as a due expiry wins. The flags stay set (or become set) and the hold count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial bit clock of the audio frame |
| lrck_i | input | 1 | Frame (left/right) clock |
| fmt_i2s_i | input | 1 | 0 = left-justified slot timing, 1 = I2S slot timing |
| ovr_l_i | input | 1 | Left overrange pulse, one system-clock cycle |
| ovr_r_i | input | 1 | Right overrange pulse, one system-clock cycle |
| ovfl_n_o | output | 1 | Active-low time-multiplexed overflow status |

## Verification
The delicate coincidence is an overrange landing in the very cycle in which the shared timer expires on a frame-clock rising edge: one function restarts the hold, and the other releases it. The bench steers the reference model until an expiry is due on the next rising half. It then drives an overrange pulse in the same system-clock cycle as that frame-clock edge. It judges the outcome by requiring the affected slots to keep reading 0 for a further full window instead of returning to 1. Random pulses placed on frame edges also produce this overlap and the overlap of a pulse with an ordinary count step.

// File: rtl/ovr_slot_pkg.sv
package ovr_slot_pkg;
  localparam int unsigned SKEW_W = 2;
  typedef logic [SKEW_W-1:0] skew_t;

  // number of serial-clock falling edges after a frame transition before the slot updates
  function automatic skew_t slot_delay(input logic fmt_i2s);
    return fmt_i2s ? skew_t'(2) : skew_t'(1);
  endfunction

  // the half with frame-clock level equal to the format bit carries the right status
  function automatic logic slot_is_right(input logic fmt_i2s, input logic lrck_level);
    return (lrck_level == fmt_i2s);
  endfunction
endpackage

// File: rtl/ovr_frame_tracker.sv
module ovr_frame_tracker
  import ovr_slot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic fmt_i2s_i,
  output logic upd_o,
  output logic right_o,
  output logic lrck_rise_o
);
  logic  sclk_q;
  logic  lrck_q;
  logic  level_q;
  skew_t fall_cnt_q;
  logic  sclk_fall;
  logic  lrck_edge;
  skew_t next_cnt;

  assign sclk_fall   = sclk_q & ~sclk_i;
  assign lrck_edge   = lrck_q ^ lrck_i;
  assign lrck_rise_o = lrck_i & ~lrck_q;
  assign next_cnt    = skew_t'(fall_cnt_q + skew_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      lrck_q     <= 1'b0;
      level_q    <= 1'b0;
      fall_cnt_q <= '1;
    end else begin
      sclk_q <= sclk_i;
      lrck_q <= lrck_i;
      if (lrck_edge) begin
        fall_cnt_q <= '0;
        level_q    <= lrck_i;
      end else if (sclk_fall && (fall_cnt_q != '1)) begin
        fall_cnt_q <= next_cnt;
      end
    end
  end

  // saturated count wraps next_cnt to zero, which never matches a delay
  assign upd_o   = sclk_fall & ~lrck_edge & (next_cnt == slot_delay(fmt_i2s_i));
  assign right_o = slot_is_right(fmt_i2s_i, level_q);
endmodule

// File: rtl/ovr_hold_timer.sv
module ovr_hold_timer #(
  parameter int unsigned HOLD_LOG2 = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ovr_l_i,
  input  logic                 ovr_r_i,
  input  logic                 tick_i,
  output logic                 flag_l_o,
  output logic                 flag_r_o,
  output logic [HOLD_LOG2-1:0] count_o,
  output logic                 expire_o
);
  logic any_hit;
  logic busy;

  assign any_hit  = ovr_l_i | ovr_r_i;
  assign busy     = flag_l_o | flag_r_o;
  assign expire_o = tick_i & busy & (count_o == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_l_o <= 1'b0;
      flag_r_o <= 1'b0;
      count_o  <= '0;
    end else if (any_hit) begin
      // a new overrange restarts the shared window and beats any due expiry
      flag_l_o <= flag_l_o | ovr_l_i;
      flag_r_o <= flag_r_o | ovr_r_i;
      count_o  <= '0;
    end else if (expire_o) begin
      flag_l_o <= 1'b0;
      flag_r_o <= 1'b0;
      count_o  <= '0;
    end else if (tick_i && busy) begin
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/ovr_slot_driver.sv
module ovr_slot_driver (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_i,
  input  logic right_i,
  input  logic flag_l_i,
  input  logic flag_r_i,
  output logic ovfl_n_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovfl_n_o <= 1'b1;
    end else if (upd_i) begin
      ovfl_n_o <= ~(right_i ? flag_r_i : flag_l_i);
    end
  end
endmodule

// File: rtl/ovr_slot_mux.sv
module ovr_slot_mux #(
  parameter int unsigned HOLD_LOG2 = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic lrck_i,
  input  logic fmt_i2s_i,
  input  logic ovr_l_i,
  input  logic ovr_r_i,
  output logic ovfl_n_o
);
  logic                 upd_w;
  logic                 right_w;
  logic                 lrck_rise_w;
  logic                 flag_l_w;
  logic                 flag_r_w;
  logic                 expire_w;
  logic [HOLD_LOG2-1:0] timer_w;

  ovr_frame_tracker u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk_i      (sclk_i),
    .lrck_i      (lrck_i),
    .fmt_i2s_i   (fmt_i2s_i),
    .upd_o       (upd_w),
    .right_o     (right_w),
    .lrck_rise_o (lrck_rise_w)
  );

  ovr_hold_timer #(.HOLD_LOG2(HOLD_LOG2)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .ovr_l_i  (ovr_l_i),
    .ovr_r_i  (ovr_r_i),
    .tick_i   (lrck_rise_w),
    .flag_l_o (flag_l_w),
    .flag_r_o (flag_r_w),
    .count_o  (timer_w),
    .expire_o (expire_w)
  );

  ovr_slot_driver u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_i    (upd_w),
    .right_i  (right_w),
    .flag_l_i (flag_l_w),
    .flag_r_i (flag_r_w),
    .ovfl_n_o (ovfl_n_o)
  );
endmodule

// File: rtl/ovr_slot_mux_checker.sv
module ovr_slot_mux_checker #(
  parameter int unsigned HOLD_LOG2 = 15
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ovr_l_i,
  input logic                 ovr_r_i,
  input logic                 upd,
  input logic                 expire,
  input logic                 flag_l,
  input logic                 flag_r,
  input logic [HOLD_LOG2-1:0] timer,
  input logic                 ovfl_n
);
  assert_set_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_l_i |=> flag_l);

  assert_set_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_r_i |=> flag_r);

  assert_release_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_l) |-> $past(expire));

  assert_release_right_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_r) |-> $past(expire));

  assert_shared_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_l_i || ovr_r_i) |=> (timer == '0));

  assert_pin_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(ovfl_n));

  assert_pulse_beats_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && (ovr_l_i || ovr_r_i)) |=> (flag_l || flag_r));
endmodule

bind ovr_slot_mux ovr_slot_mux_checker #(.HOLD_LOG2(HOLD_LOG2)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ovr_l_i (ovr_l_i),
  .ovr_r_i (ovr_r_i),
  .upd     (upd_w),
  .expire  (expire_w),
  .flag_l  (flag_l_w),
  .flag_r  (flag_r_w),
  .timer   (timer_w),
  .ovfl_n  (ovfl_n_o)
);

// File: tb/tb_ovr_slot_mux.sv
`timescale 1ns/1ps
module tb_ovr_slot_mux;
  localparam int unsigned HOLD_LOG2 = 3;
  localparam int HOLD = 1 << HOLD_LOG2;
  localparam int SCLK_PER_HALF = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_i = 1'b1;
  logic lrck_i = 1'b0;
  logic fmt_i2s_i = 1'b0;
  logic ovr_l_i = 1'b0;
  logic ovr_r_i = 1'b0;
  logic ovfl_n_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  bit m_l, m_r, cur_lvl, prev_pin;
  int m_cnt;

  always #2.5 clk = ~clk;

  ovr_slot_mux #(.HOLD_LOG2(HOLD_LOG2)) dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .lrck_i(lrck_i),
    .fmt_i2s_i(fmt_i2s_i), .ovr_l_i(ovr_l_i), .ovr_r_i(ovr_r_i),
    .ovfl_n_o(ovfl_n_o)
  );

  function automatic int exp_delay(bit i2s);
    return i2s ? 2 : 1;
  endfunction

  function automatic bit exp_right(bit i2s, bit lvl);
    // LJ: low half right; I2S: high half right
    return i2s ? lvl : !lvl;
  endfunction

  task automatic chk(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s fmt_i2s=%0b got %0b expected %0b at %0t", tag, fmt_i2s_i, act, exp, $time);
    end
  endtask

  task automatic model_step(bit pl, bit pr, bit rise);
    if (pl || pr) begin
      m_cnt = 0; m_l |= pl; m_r |= pr;
    end else if (rise && (m_l || m_r)) begin
      if (m_cnt == HOLD - 1) begin m_l = 0; m_r = 0; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  task automatic do_reset(bit i2s);
    @(negedge clk);
    rst_n = 1'b0; sclk_i = 1'b1; lrck_i = 1'b0; ovr_l_i = 0; ovr_r_i = 0;
    fmt_i2s_i = i2s;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    m_l = 0; m_r = 0; m_cnt = 0; cur_lvl = 0; prev_pin = 1;
    @(negedge clk);
    chk("R1", ovfl_n_o, 1'b1);
  endtask

  // one half-frame: pulses at sclk index 0 (on the frame edge) and/or index 8
  task automatic do_half(string tag, bit p0_l, bit p0_r, bit p8_l, bit p8_r);
    bit new_lvl, newexp;
    int d;
    new_lvl = !cur_lvl;
    model_step(p0_l, p0_r, new_lvl);
    cur_lvl = new_lvl;
    newexp = !(exp_right(fmt_i2s_i, new_lvl) ? m_r : m_l);
    d = exp_delay(fmt_i2s_i);
    for (int k = 0; k < SCLK_PER_HALF; k++) begin
      @(negedge clk);
      sclk_i = 1'b0;
      if (k == 0) lrck_i = new_lvl;
      ovr_l_i = (k == 0 && p0_l) || (k == 8 && p8_l);
      ovr_r_i = (k == 0 && p0_r) || (k == 8 && p8_r);
      @(negedge clk);
      ovr_l_i = 1'b0; ovr_r_i = 1'b0;
      if (k == d - 1) chk(fmt_i2s_i ? "R6 early" : "R5 early", ovfl_n_o, prev_pin);
      if (k == d) chk(tag, ovfl_n_o, newexp);
      if (k == SCLK_PER_HALF - 1) chk("R8 hold", ovfl_n_o, newexp);
      if (k == 8) model_step(p8_l, p8_r, 1'b0);
      @(negedge clk);
      sclk_i = 1'b1;
      @(negedge clk);
    end
    prev_pin = newexp;
  endtask

  task automatic run_format(bit i2s);
    do_reset(i2s);
    // R1: idle frames stay high
    repeat (4) do_half("R1", 0, 0, 0, 0);
    // R2 / R7: one left hit, then both slots observed
    do_half("R2", 0, 0, 1, 0);
    repeat (3) do_half("R7", 0, 0, 0, 0);
    // R3: quiet until release
    repeat (2 * HOLD + 4) do_half("R3", 0, 0, 0, 0);
    // R4: left hit, right hit later keeps left held
    do_half("R4", 0, 0, 1, 0);
    repeat (HOLD) do_half("R4", 0, 0, 0, 0);
    do_half("R4", 0, 0, 0, 1);
    repeat (2 * HOLD + 2) do_half("R4", 0, 0, 0, 0);
    // R9: pulse lands on the frame edge whose expiry is due
    do_half("R9", 0, 0, 0, 1);
    for (int n = 0; n < 4 * HOLD; n++) begin
      if ((m_l || m_r) && m_cnt == HOLD - 1 && !cur_lvl) begin
        do_half("R9", 0, 1, 0, 0);
        break;
      end
      do_half("R9", 0, 0, 0, 0);
    end
    repeat (2 * HOLD + 2) do_half("R9", 0, 0, 0, 0);
    // random mix
    for (int n = 0; n < 90; n++) begin
      int r;
      r = $urandom_range(0, 11);
      do_half("R7", r == 3, r == 4 || r == 5, r == 0 || r == 2, r == 1 || r == 2 || r == 5);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) got hang expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    run_format(1'b0);
    run_format(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule